// File: doc/BRIEF.md
# Port Event and Interrupt Aggregator

This block gathers fault and status flags from the ports of a four-port power-sourcing controller, plus one group of chip-wide flags such as supply and temperature alarms. It turns them into sticky event bits and folds them through per-source enable masks into an interrupt summary register. That summary drives an active-low, open-drain style interrupt pin. A host reads and clears the events and programs the masks over a simple strobe-based register port.

Changes are not committed the moment they arrive. A monitor sequencer steps through the ports, one per measurement slot of `TICK_CYCLES` clocks, which stands in for the millisecond measurement cadence. At the end of each slot it runs a four-cycle commit for the visited source. The order is status snapshot, then event merge, then the interrupt summary bit, then the pin. The chip-wide group is visited together with the last port on every second round, so it is sampled at half the port rate. As a result the pin can trail the event registers by up to a full round. Flag edges that arrive between visits are held as pending and are never lost.

The register port has no back-pressure. A read or write strobe is accepted in the cycle it is presented. Read data returns one cycle later with `rd_valid`. Flags are plain level inputs.

Top module: `pse_event_aggregator`

## Requirements
- R1: After reset every event, status, pending and interrupt summary bit is zero, every mask reads all ones, and `irq_n` is high.
- R2: A rising edge on any flag bit marks that bit pending. At the next commit of its source the pending bits are OR-ed into the event register, where they stay until cleared by a clear-on-read access.
- R3: A read of an event register at its plain address returns its bits and changes nothing.
- R4: A read of the clear-on-read alias returns the bits as they were before the access and leaves the register zero on the next cycle.
- R5: When a clear-on-read access and an event commit of the same source fall on the same clock edge, the newly committed bits stay set and only the older bits are cleared.
- R6: The interrupt summary register holds bit p for port p and bit NUM_PORTS for the chip-wide group. Each bit is rewritten only during its source's summary cycle, with the OR of (event AND mask). It is read at address 0x00.
- R7: `irq_n` is rewritten only in the pin cycle, one cycle after the summary cycle. It is low exactly when the summary register is non-zero, so after a clear the pin stays low until the source's next visit.
- R8: Slots count from the release of reset. In slot k, port k mod NUM_PORTS is visited. The edges of slot k are: tick at edge (k+1)·TICK_CYCLES, status snapshot at +1, event commit at +2, summary at +3 and pin at +4.
- R9: The chip-wide group is visited in the same slot as the last port, on odd rounds only. Round r covers slots r·NUM_PORTS to r·NUM_PORTS+NUM_PORTS−1.
- R10: A status register holds the raw flag levels of its source captured in the snapshot cycle.
- R11: The chip-wide registers sit at these addresses: mask 0x01 (read/write), event 0x02, clear-on-read alias 0x03, status 0x04. Port p uses base 0x08+4p: status +0, event +1, clear-on-read alias +2, mask +3 (read/write). Writes to any other address are ignored, and a masked event cannot pull the pin low.
- R12: Read data appears in the cycle after a read strobe, with `rd_valid` high for exactly that cycle. Unmapped addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| port_flags | input | NUM_PORTS*FLAG_W | Raw flags, port p in bits [p*FLAG_W +: FLAG_W] |
| glb_flags | input | FLAG_W | Raw chip-wide flags |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | ADDR_W | Register address for read or write |
| wdata | input | FLAG_W | Write data |
| rdata | output | FLAG_W | Read data, valid with rd_valid |
| rd_valid | output | 1 | High for the cycle after a read strobe |
| irq_n | output | 1 | Interrupt, active low |

## Verification
The collision that matters is a clear-on-read access landing on the same edge as the sequencer's event commit for that same source. Because the slot timing follows from reset release, the bench counts edges and places the alias read exactly on port 0's commit edge, with one older event already set and one new edge pending. The read must return only the old bit, and a following plain read must show only the new bit. The same edge counting checks that the pin holds low after a clear until the port's next pin cycle, and no sooner.

// File: rtl/pse_evt_pkg.sv
package pse_evt_pkg;

  localparam int ADR_IRQ     = 0;
  localparam int ADR_GMASK   = 1;
  localparam int ADR_GEVT    = 2;
  localparam int ADR_GCOR    = 3;
  localparam int ADR_GSTAT   = 4;
  localparam int ADR_PBASE   = 8;
  localparam int ADR_PSTRIDE = 4;
  localparam int OFF_STAT    = 0;
  localparam int OFF_EVT     = 1;
  localparam int OFF_COR     = 2;
  localparam int OFF_MASK    = 3;

  // one strobe per commit step, in commit order
  typedef struct packed {
    logic snap;
    logic commit;
    logic summ;
    logic pin;
  } stage_t;

  function automatic int port_addr(input int p, input int off);
    return ADR_PBASE + p * ADR_PSTRIDE + off;
  endfunction

endpackage

// File: rtl/pse_evt_sequencer.sv
module pse_evt_sequencer
  import pse_evt_pkg::*;
#(
  parameter int NUM_PORTS   = 4,
  parameter int TICK_CYCLES = 3000
) (
  input  logic               clk,
  input  logic               rst_n,
  output logic [NUM_PORTS:0] vis,
  output stage_t             stb
);
  localparam int CW = $clog2(TICK_CYCLES);
  localparam int PW = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;
  localparam logic [CW-1:0] TICK_LAST = CW'(TICK_CYCLES - 1);
  localparam logic [PW-1:0] PORT_LAST = PW'(NUM_PORTS - 1);

  logic [CW-1:0]      cnt;
  logic [PW-1:0]      slot;
  logic               odd_round;
  logic [3:0]         pipe;
  logic               tick;
  logic [NUM_PORTS:0] vis_next;

  assign tick = (cnt == TICK_LAST);

  always_comb begin
    vis_next = '0;
    vis_next[slot] = 1'b1;
    vis_next[NUM_PORTS] = (slot == PORT_LAST) && odd_round;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt       <= '0;
      slot      <= '0;
      odd_round <= 1'b0;
      pipe      <= '0;
      vis       <= '0;
    end else begin
      cnt  <= tick ? '0 : cnt + 1'b1;
      pipe <= tick ? 4'b0001 : {pipe[2:0], 1'b0};
      if (tick) begin
        vis <= vis_next;
        if (slot == PORT_LAST) begin
          slot      <= '0;
          odd_round <= ~odd_round;
        end else begin
          slot <= slot + 1'b1;
        end
      end
    end
  end

  assign stb.snap   = pipe[0];
  assign stb.commit = pipe[1];
  assign stb.summ   = pipe[2];
  assign stb.pin    = pipe[3];

endmodule

// File: rtl/pse_evt_source.sv
module pse_evt_source #(
  parameter int FLAG_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FLAG_W-1:0] raw,
  input  logic              snap,
  input  logic              commit,
  input  logic              clr,
  input  logic              mask_we,
  input  logic [FLAG_W-1:0] mask_wd,
  output logic [FLAG_W-1:0] status,
  output logic [FLAG_W-1:0] evt,
  output logic [FLAG_W-1:0] pend,
  output logic [FLAG_W-1:0] mask,
  output logic              hit
);
  logic [FLAG_W-1:0] raw_q;
  logic [FLAG_W-1:0] rise;

  assign rise = raw & ~raw_q;
  assign hit  = |(evt & mask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      raw_q  <= '0;
      pend   <= '0;
      status <= '0;
      evt    <= '0;
      mask   <= '1;
    end else begin
      raw_q <= raw;
      // edges seen in the commit cycle itself wait for the next visit
      pend  <= (commit ? '0 : pend) | rise;
      if (snap) status <= raw;
      // a commit on the clearing edge survives the clear
      evt   <= (clr ? '0 : evt) | (commit ? pend : '0);
      if (mask_we) mask <= mask_wd;
    end
  end

endmodule

// File: rtl/pse_evt_irq.sv
module pse_evt_irq #(
  parameter int NUM_SRC = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               summ_stb,
  input  logic               pin_stb,
  input  logic [NUM_SRC-1:0] vis,
  input  logic [NUM_SRC-1:0] hit,
  output logic [NUM_SRC-1:0] summary,
  output logic               irq_n
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      summary <= '0;
      irq_n   <= 1'b1;
    end else begin
      if (summ_stb) summary <= (summary & ~vis) | (hit & vis);
      if (pin_stb)  irq_n   <= ~|summary;
    end
  end

endmodule

// File: rtl/pse_event_aggregator.sv
module pse_event_aggregator
  import pse_evt_pkg::*;
#(
  parameter int NUM_PORTS   = 4,
  parameter int FLAG_W      = 8,
  parameter int ADDR_W      = 5,
  parameter int TICK_CYCLES = 3000
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_PORTS*FLAG_W-1:0] port_flags,
  input  logic [FLAG_W-1:0]           glb_flags,
  input  logic                        rd_en,
  input  logic                        wr_en,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [FLAG_W-1:0]           wdata,
  output logic [FLAG_W-1:0]           rdata,
  output logic                        rd_valid,
  output logic                        irq_n
);
  localparam int NUM_SRC = NUM_PORTS + 1;
  localparam int GSRC    = NUM_PORTS;

  logic [NUM_SRC-1:0] vis;
  stage_t             seq_stb;
  logic [NUM_SRC-1:0] hit;
  logic [NUM_SRC-1:0] summary;

  logic [FLAG_W-1:0] p_status [NUM_PORTS];
  logic [FLAG_W-1:0] p_evt    [NUM_PORTS];
  logic [FLAG_W-1:0] p_mask   [NUM_PORTS];

  logic [FLAG_W-1:0] g_status, g_evt, g_pend, g_mask;
  logic              g_commit, g_clr;
  logic [FLAG_W-1:0] rd_mux;

  pse_evt_sequencer #(
    .NUM_PORTS  (NUM_PORTS),
    .TICK_CYCLES(TICK_CYCLES)
  ) u_seq (
    .clk  (clk),
    .rst_n(rst_n),
    .vis  (vis),
    .stb  (seq_stb)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic              clr_p, we_p;
    logic [FLAG_W-1:0] pend_p;
    assign clr_p = rd_en && (addr == ADDR_W'(port_addr(p, OFF_COR)));
    assign we_p  = wr_en && (addr == ADDR_W'(port_addr(p, OFF_MASK)));

    pse_evt_source #(.FLAG_W(FLAG_W)) u_src (
      .clk    (clk),
      .rst_n  (rst_n),
      .raw    (port_flags[p*FLAG_W +: FLAG_W]),
      .snap   (seq_stb.snap && vis[p]),
      .commit (seq_stb.commit && vis[p]),
      .clr    (clr_p),
      .mask_we(we_p),
      .mask_wd(wdata),
      .status (p_status[p]),
      .evt    (p_evt[p]),
      .pend   (pend_p),
      .mask   (p_mask[p]),
      .hit    (hit[p])
    );
  end

  assign g_commit = seq_stb.commit && vis[GSRC];
  assign g_clr    = rd_en && (addr == ADDR_W'(ADR_GCOR));

  pse_evt_source #(.FLAG_W(FLAG_W)) u_glb (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw    (glb_flags),
    .snap   (seq_stb.snap && vis[GSRC]),
    .commit (g_commit),
    .clr    (g_clr),
    .mask_we(wr_en && (addr == ADDR_W'(ADR_GMASK))),
    .mask_wd(wdata),
    .status (g_status),
    .evt    (g_evt),
    .pend   (g_pend),
    .mask   (g_mask),
    .hit    (hit[GSRC])
  );

  pse_evt_irq #(.NUM_SRC(NUM_SRC)) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .summ_stb(seq_stb.summ),
    .pin_stb (seq_stb.pin),
    .vis     (vis),
    .hit     (hit),
    .summary (summary),
    .irq_n   (irq_n)
  );

  always_comb begin
    rd_mux = '0;
    if (addr == ADDR_W'(ADR_IRQ))   rd_mux = FLAG_W'(summary);
    if (addr == ADDR_W'(ADR_GMASK)) rd_mux = g_mask;
    if (addr == ADDR_W'(ADR_GEVT))  rd_mux = g_evt;
    if (addr == ADDR_W'(ADR_GCOR))  rd_mux = g_evt;
    if (addr == ADDR_W'(ADR_GSTAT)) rd_mux = g_status;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (addr == ADDR_W'(port_addr(p, OFF_STAT))) rd_mux = p_status[p];
      if (addr == ADDR_W'(port_addr(p, OFF_EVT)))  rd_mux = p_evt[p];
      if (addr == ADDR_W'(port_addr(p, OFF_COR)))  rd_mux = p_evt[p];
      if (addr == ADDR_W'(port_addr(p, OFF_MASK))) rd_mux = p_mask[p];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata    <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rdata <= rd_mux;
    end
  end

endmodule

// File: rtl/pse_evt_checks.sv
module pse_evt_checks
  import pse_evt_pkg::*;
#(
  parameter int FLAG_W = 8,
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_en,
  input logic              rd_valid,
  input logic [ADDR_W-1:0] addr,
  input logic              g_commit,
  input logic [FLAG_W-1:0] g_evt,
  input logic [FLAG_W-1:0] g_pend,
  input stage_t            stb,
  input logic              irq_n
);
  logic g_cor;
  assign g_cor = rd_en && (addr == ADDR_W'(ADR_GCOR));

  p_read_valid_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);

  p_idle_valid_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);

  p_pin_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !stb.pin |=> $stable(irq_n));

  p_cor_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (g_cor && !g_commit) |=> (g_evt == '0));

  p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!g_cor && !g_commit) |=> (g_evt == $past(g_evt)));

  p_commit_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (g_cor && g_commit) |=> (g_evt == $past(g_pend)));

  p_one_stage_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(stb));

endmodule

bind pse_event_aggregator pse_evt_checks #(
  .FLAG_W(FLAG_W),
  .ADDR_W(ADDR_W)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .rd_en   (rd_en),
  .rd_valid(rd_valid),
  .addr    (addr),
  .g_commit(g_commit),
  .g_evt   (g_evt),
  .g_pend  (g_pend),
  .stb     (seq_stb),
  .irq_n   (irq_n)
);

// File: tb/pse_event_aggregator_tb.sv
module pse_event_aggregator_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NP   = 4;
  localparam int FW   = 8;
  localparam int AW   = 5;
  localparam int TICK = 16;
  localparam int SETTLE = 2 * NP * TICK + 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NP*FW-1:0] port_flags = '0;
  logic [FW-1:0]   glb_flags = '0;
  logic            rd_en = 1'b0, wr_en = 1'b0;
  logic [AW-1:0]   addr = '0;
  logic [FW-1:0]   wdata = '0;
  logic [FW-1:0]   rdata;
  logic            rd_valid, irq_n;

  int checks = 0, fails = 0, ecnt = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) ecnt <= rst_n ? ecnt + 1 : 0;

  pse_event_aggregator #(
    .NUM_PORTS(NP), .FLAG_W(FW), .ADDR_W(AW), .TICK_CYCLES(TICK)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .port_flags(port_flags), .glb_flags(glb_flags),
    .rd_en(rd_en), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .rd_valid(rd_valid), .irq_n(irq_n)
  );

  function automatic logic [AW-1:0] pa(input int p, input int off);
    return AW'(8 + 4 * p + off);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; port_flags = '0; glb_flags = '0; rd_en = 0; wr_en = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic at_edge(input int n);
    @(negedge clk);
    while (ecnt != n) @(negedge clk);
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [FW-1:0] d);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0; d = rdata;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [FW-1:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  typedef struct packed {
    logic [3:0]    port;
    logic [FW-1:0] pulse;
    logic [FW-1:0] mask;
    logic [FW-1:0] expe;
    logic          pinlow;
  } vec_t;

  localparam vec_t VEC [5] = '{
    '{4'd0, 8'h01, 8'hFF, 8'h01, 1'b1},
    '{4'd1, 8'h06, 8'hFF, 8'h06, 1'b1},
    '{4'd2, 8'h80, 8'h7F, 8'h80, 1'b0},
    '{4'd3, 8'hA0, 8'h20, 8'hA0, 1'b1},
    '{4'd1, 8'h00, 8'hFF, 8'h00, 1'b0}
  };

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: run did not finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [FW-1:0] d;
    do_reset();
    // R1 reset state
    chk("R1 irq_n", irq_n, 1);
    rd(pa(0, 3), d); chk("R1 port mask", d, 8'hFF);
    rd(AW'(1), d);   chk("R1 global mask", d, 8'hFF);
    rd(pa(2, 1), d); chk("R1 port event", d, 0);
    rd(AW'(0), d);   chk("R1 summary", d, 0);

    // vector table: R2 R3 R4 R6 R7 R11
    for (int i = 0; i < 5; i++) begin
      int p = int'(VEC[i].port);
      wr(pa(p, 3), VEC[i].mask);
      @(negedge clk); port_flags[p*FW +: FW] = VEC[i].pulse;
      @(negedge clk); port_flags[p*FW +: FW] = '0;
      repeat (SETTLE) @(negedge clk);
      rd(pa(p, 1), d); chk("R2 event set", d, VEC[i].expe);
      rd(pa(p, 1), d); chk("R3 plain read keeps", d, VEC[i].expe);
      chk("R11 pin vs mask", !irq_n, VEC[i].pinlow);
      rd(AW'(0), d);   chk("R6 summary bit", d, VEC[i].pinlow ? (8'h1 << p) : 8'h0);
      rd(pa(p, 2), d); chk("R4 alias returns", d, VEC[i].expe);
      rd(pa(p, 1), d); chk("R4 alias cleared", d, 0);
      repeat (SETTLE) @(negedge clk);
      chk("R7 pin released", irq_n, 1);
    end

    // collision and timing, edges counted from reset release
    do_reset();
    at_edge(2);  port_flags[0] = 1'b1;
    at_edge(3);  port_flags[0] = 1'b0;
    at_edge(19); chk("R7 pin not before pin cycle", irq_n, 1);
    at_edge(20); chk("R8 pin after slot 0", irq_n, 0);
    at_edge(69); port_flags[1] = 1'b1;
    at_edge(70); port_flags[1] = 1'b0;
    at_edge(81); rd_en = 1; addr = pa(0, 2);
    at_edge(82); chk("R4 alias old bits", rdata, 8'h01); addr = pa(0, 1);
    at_edge(83); chk("R5 commit survives clear", rdata, 8'h02); addr = pa(0, 2);
    at_edge(84); rd_en = 0; chk("R4 alias read", rdata, 8'h02);
    at_edge(85); chk("R7 pin lags clear", irq_n, 0);
    at_edge(147); chk("R7 pin holds until pin cycle", irq_n, 0);
    at_edge(148); chk("R8 pin released at next visit", irq_n, 1);

    // chip-wide group: R9 R10
    at_edge(149); glb_flags = 8'h05;
    at_edge(150); glb_flags = 8'h01;
    at_edge(257); rd_en = 1; addr = AW'(2);
    at_edge(258); chk("R9 global not before commit", rdata, 0);
    at_edge(259); chk("R9 global committed slot 15", rdata, 8'h05); addr = AW'(4);
    at_edge(260); chk("R10 global status", rdata, 8'h01); chk("R9 global pin", irq_n, 0);
    addr = AW'(0);
    at_edge(261); rd_en = 0; chk("R6 global summary bit", rdata, 8'h10);

    // R11 ignored writes, R12 read path
    wr(AW'(2), 8'h00);
    wr(AW'(0), 8'hFF);
    rd(AW'(2), d); chk("R11 write to event ignored", d, 8'h05);
    rd(AW'(0), d); chk("R11 write to summary ignored", d, 8'h10);
    @(negedge clk); rd_en = 1; addr = AW'(5);
    @(negedge clk); rd_en = 0;
    chk("R12 valid after strobe", rd_valid, 1); chk("R12 unmapped zero", rdata, 0);
    @(negedge clk); chk("R12 valid one cycle", rd_valid, 0);
    wr(AW'(1), 8'h00);
    rd(AW'(1), d); chk("R11 global mask write", d, 0);
    repeat (SETTLE) @(negedge clk);
    chk("R11 masked global releases pin", irq_n, 1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule